// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and makes its exceptions precise. Each stage can flag a fault for the instruction it currently holds. The unit keeps a shadow pipeline of valid bit, PC and cause for every instruction in flight. The first cause recorded for an instruction travels with it. Nothing is acted on until that instruction reaches writeback. At that point the unit reports the trap and captures the faulting PC and cause. It squashes the faulting instruction and everything behind it, and one cycle later it steers fetch to a fixed handler address.

Faults can arrive out of program order: a young instruction can fault in fetch before an older one faults in memory. Several faults can also arrive in the same cycle. Because a cause is only honoured at writeback, older instructions always retire first and the oldest fault is always the one reported. An interrupt request is attached to the oldest valid instruction still in flight and is treated like any other cause. The pipeline around the unit advances every cycle. The unit supplies commit and store qualifiers that the datapath uses to suppress side effects of squashed or faulting instructions.

Top module: `pec_commit_unit`

## Requirements
- R1: After reset no instruction is in flight, `commit_o`, `flush_o` and `redirect_o` are low, and `epc_o` and `cause_o` read zero.
- R2: An instruction accepted at fetch in cycle t with no cause is in writeback in cycle t+4, where `commit_o` is high and `commit_pc_o` equals its PC.
- R3: Cause codes are: 0 none, 1 fetch page fault, 2 fetch misaligned, 3 fetch protection, 4 illegal opcode, 5 arithmetic overflow, 6 data page fault, 7 data misaligned, 8 data protection, 9 interrupt. A nonzero cause raised in any stage takes effect only when that instruction is in writeback. In that cycle `flush_o` is high and `commit_o` is low, and at the end of that cycle `epc_o` takes its PC and `cause_o` takes its cause.
- R4: The first cause recorded for an instruction is kept; a cause raised for it in a later stage is ignored.
- R5: When an older and a younger instruction both fault, in either time order or in the same cycle, the older one's PC and cause are reported and the younger never commits.
- R6: A trap empties every stage. An instruction offered at fetch in the trap cycle or in the cycle after it is discarded. An instruction fetched two cycles after the trap commits normally.
- R7: `redirect_o` is high in exactly the cycle after a trap, with `redirect_pc_o` equal to the handler address parameter.
- R8: `mem_store_ok_o` is high only when a valid memory-stage instruction carries no cause, including a cause raised in that stage in that cycle.
- R9: While `irq_i` is high, cause 9 is attached to the oldest valid instruction in fetch, decode, execute or memory, provided that instruction has no cause yet. A fault raised by that instruction's stage in the same cycle wins over the interrupt.
- R10: `epc_o` and `cause_o` hold their values in every cycle without a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | An instruction is present in the fetch stage |
| fetch_pc_i | input | PC_W | PC of the fetch-stage instruction |
| if_exc_i | input | 4 | Cause raised by fetch for its instruction (0 = none) |
| id_exc_i | input | 4 | Cause raised by decode for its instruction |
| ex_exc_i | input | 4 | Cause raised by execute for its instruction |
| mem_exc_i | input | 4 | Cause raised by memory for its instruction |
| irq_i | input | 1 | Level interrupt request |
| commit_o | output | 1 | Writeback instruction retires (register write allowed) |
| commit_pc_o | output | PC_W | PC of the retiring instruction |
| mem_store_ok_o | output | 1 | Memory-stage write allowed |
| flush_o | output | 1 | Trap taken this cycle; all stages squashed |
| redirect_o | output | 1 | Fetch must restart at the handler |
| redirect_pc_o | output | PC_W | Handler address |
| epc_o | output | PC_W | Saved PC of the last trapping instruction |
| cause_o | output | 4 | Saved cause of the last trap |

## Verification
The assertions check four properties on every cycle. A trap is always followed by a redirect and by empty stages. Nothing commits during a redirect. The saved PC and cause only change on a trap, and a cause already recorded is never replaced. An allowed store is always followed by that instruction committing. Only the bench scenarios can show that the oldest fault wins when faults arrive out of order or in the same cycle, and that discarded fetches really stay discarded. They also show how an interrupt competes with a synchronous fault for the same instruction.

// File: rtl/pec_pkg.sv
package pec_pkg;
   localparam int CAUSE_W = 4;
   localparam int N_PIPE  = 4;   // pipeline registers: IF/ID, ID/EX, EX/MEM, MEM/WB

   typedef logic [CAUSE_W-1:0] cause_t;

   localparam cause_t C_NONE  = 4'd0;
   localparam cause_t C_IPF   = 4'd1;
   localparam cause_t C_IMIS  = 4'd2;
   localparam cause_t C_IPROT = 4'd3;
   localparam cause_t C_ILL   = 4'd4;
   localparam cause_t C_OVF   = 4'd5;
   localparam cause_t C_DPF   = 4'd6;
   localparam cause_t C_DMIS  = 4'd7;
   localparam cause_t C_DPROT = 4'd8;
   localparam cause_t C_IRQ   = 4'd9;
endpackage

// File: rtl/pec_stage_reg.sv
module pec_stage_reg
   import pec_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush_i,
   input  logic            valid_i,
   input  logic [PC_W-1:0] pc_i,
   input  cause_t          rec_i,
   input  cause_t          raise_i,
   input  logic            irq_att_i,
   output cause_t          merged_o,
   output logic            valid_q,
   output logic [PC_W-1:0] pc_q,
   output cause_t          cause_q
);
   // oldest recorded cause wins, then this stage's fault, then an interrupt
   always_comb begin
      merged_o = C_NONE;
      if (valid_i) begin
         if (rec_i != C_NONE)        merged_o = rec_i;
         else if (raise_i != C_NONE) merged_o = raise_i;
         else if (irq_att_i)         merged_o = C_IRQ;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pc_q    <= '0;
         cause_q <= C_NONE;
      end else begin
         valid_q <= valid_i & ~flush_i;
         pc_q    <= pc_i;
         cause_q <= (valid_i & ~flush_i) ? merged_o : C_NONE;
      end
   end

   // R4: a cause recorded upstream survives the hop unchanged
   a_r4_first_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !flush_i && rec_i != C_NONE) |=> (valid_q && cause_q == $past(rec_i)));
endmodule

// File: rtl/pec_irq_sel.sv
module pec_irq_sel #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         irq_i,
   input  logic         block_i,
   input  logic [N-1:0] valid_i,
   input  logic [N-1:0] free_i,
   output logic [N-1:0] att_o
);
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   logic [IDX_W-1:0] oldest;
   logic             found;

   // higher index = further down the pipe = older
   always_comb begin
      oldest = '0;
      found  = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (valid_i[i]) begin
            oldest = IDX_W'(i);
            found  = 1'b1;
         end
      end
      att_o = '0;
      if (irq_i && !block_i && found && free_i[oldest]) att_o[oldest] = 1'b1;
   end

   // R9: an interrupt lands on at most one instruction
   a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(att_o));
endmodule

// File: rtl/pec_trap_ctrl.sv
module pec_trap_ctrl
   import pec_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wb_valid_i,
   input  logic [PC_W-1:0] wb_pc_i,
   input  cause_t          wb_cause_i,
   output logic            trap_o,
   output logic            commit_o,
   output logic [PC_W-1:0] commit_pc_o,
   output logic            redirect_o,
   output logic [PC_W-1:0] redirect_pc_o,
   output logic [PC_W-1:0] epc_o,
   output cause_t          cause_o
);
   assign trap_o        = wb_valid_i && (wb_cause_i != C_NONE);
   assign commit_o      = wb_valid_i && (wb_cause_i == C_NONE);
   assign commit_pc_o   = wb_pc_i;
   assign redirect_pc_o = HANDLER_PC;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_o      <= '0;
         cause_o    <= C_NONE;
         redirect_o <= 1'b0;
      end else begin
         redirect_o <= trap_o;
         if (trap_o) begin
            epc_o   <= wb_pc_i;
            cause_o <= wb_cause_i;
         end
      end
   end

   // R7: fetch is steered away in the cycle after every trap
   a_r7_redirect_follows: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |=> redirect_o);
   // R10: saved state only moves on a trap
   a_r10_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_o |=> ($stable(epc_o) && $stable(cause_o)));
   // R6: the pipe is empty while fetch restarts
   a_r6_no_commit_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> !commit_o);
endmodule

// File: rtl/pec_commit_unit.sv
module pec_commit_unit
   import pec_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fetch_valid_i,
   input  logic [PC_W-1:0] fetch_pc_i,
   input  logic [3:0]      if_exc_i,
   input  logic [3:0]      id_exc_i,
   input  logic [3:0]      ex_exc_i,
   input  logic [3:0]      mem_exc_i,
   input  logic            irq_i,
   output logic            commit_o,
   output logic [PC_W-1:0] commit_pc_o,
   output logic            mem_store_ok_o,
   output logic            flush_o,
   output logic            redirect_o,
   output logic [PC_W-1:0] redirect_pc_o,
   output logic [PC_W-1:0] epc_o,
   output logic [3:0]      cause_o
);
   localparam int N_ST  = N_PIPE + 1;   // IF..WB
   localparam int MEM_S = N_PIPE - 1;

   if (PC_W < 8) begin : g_bad_pcw
      $error("pec_commit_unit: PC_W too small");
   end
   if (HANDLER_PC[1:0] != 2'b00) begin : g_bad_handler
      $error("pec_commit_unit: handler address must be word aligned");
   end
   if (CAUSE_W != 4) begin : g_bad_cw
      $error("pec_commit_unit: cause width must match port width");
   end

   logic            stg_v   [N_ST];
   logic [PC_W-1:0] stg_pc  [N_ST];
   cause_t          stg_rec [N_ST];
   cause_t          raise   [N_PIPE];
   cause_t          merged  [N_PIPE];
   logic [N_PIPE-1:0] valid_v, free_v, att_v;
   logic            trap;

   assign raise[0] = if_exc_i;
   assign raise[1] = id_exc_i;
   assign raise[2] = ex_exc_i;
   assign raise[3] = mem_exc_i;

   // fetch input is dropped during the trap cycle and the redirect cycle
   assign stg_v[0]   = fetch_valid_i & ~trap & ~redirect_o;
   assign stg_pc[0]  = fetch_pc_i;
   assign stg_rec[0] = C_NONE;

   always_comb begin
      for (int s = 0; s < N_PIPE; s++) begin
         valid_v[s] = stg_v[s] & ~trap;
         free_v[s]  = (stg_rec[s] == C_NONE) && (raise[s] == C_NONE);
      end
   end

   pec_irq_sel #(.N(N_PIPE)) irq_sel_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_i   (irq_i),
      .block_i (trap),
      .valid_i (valid_v),
      .free_i  (free_v),
      .att_o   (att_v)
   );

   for (genvar s = 0; s < N_PIPE; s++) begin : g_stage
      pec_stage_reg #(.PC_W(PC_W)) stage_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush_i   (trap),
         .valid_i   (stg_v[s]),
         .pc_i      (stg_pc[s]),
         .rec_i     (stg_rec[s]),
         .raise_i   (raise[s]),
         .irq_att_i (att_v[s]),
         .merged_o  (merged[s]),
         .valid_q   (stg_v[s+1]),
         .pc_q      (stg_pc[s+1]),
         .cause_q   (stg_rec[s+1])
      );
   end

   pec_trap_ctrl #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) trap_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .wb_valid_i    (stg_v[N_PIPE]),
      .wb_pc_i       (stg_pc[N_PIPE]),
      .wb_cause_i    (stg_rec[N_PIPE]),
      .trap_o        (trap),
      .commit_o      (commit_o),
      .commit_pc_o   (commit_pc_o),
      .redirect_o    (redirect_o),
      .redirect_pc_o (redirect_pc_o),
      .epc_o         (epc_o),
      .cause_o       (cause_o)
   );

   assign flush_o        = trap;
   assign mem_store_ok_o = stg_v[MEM_S] && (merged[MEM_S] == C_NONE) && !trap;

   // R6: a trap leaves every pipeline register empty
   a_r6_stages_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> (!stg_v[1] && !stg_v[2] && !stg_v[3] && !stg_v[4]));
   // R8: an allowed store belongs to an instruction that then retires
   a_r8_store_then_commit: assert property (@(posedge clk) disable iff (!rst_n)
      mem_store_ok_o |=> commit_o);
endmodule

// File: tb/pec_commit_unit_tb.sv
`timescale 1ns/1ps
module pec_commit_unit_tb_top;
   localparam logic [31:0] HANDLER = 32'h0000_0180;
   localparam int NONE_S = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic [3:0]  if_exc = '0, id_exc = '0, ex_exc = '0, mem_exc = '0;
   logic        irq = 1'b0;
   logic        commit, store_ok, flush, redirect;
   logic [31:0] commit_pc, redirect_pc, epc;
   logic [3:0]  cause;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [31:0] exp_epc = '0;
   logic [3:0]  exp_cause = '0;

   always #2 clk = ~clk;

   pec_commit_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid_i(fetch_valid), .fetch_pc_i(fetch_pc),
      .if_exc_i(if_exc), .id_exc_i(id_exc), .ex_exc_i(ex_exc), .mem_exc_i(mem_exc),
      .irq_i(irq),
      .commit_o(commit), .commit_pc_o(commit_pc), .mem_store_ok_o(store_ok),
      .flush_o(flush), .redirect_o(redirect), .redirect_pc_o(redirect_pc),
      .epc_o(epc), .cause_o(cause)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // each vector: {a_stage, a_code, b_stage, b_code}, stage 7 = no fault
   localparam int NV = 9;
   localparam logic [13:0] VEC [NV] = '{
      {3'd7, 4'd0, 3'd7, 4'd0},
      {3'd0, 4'd1, 3'd7, 4'd0},
      {3'd7, 4'd0, 3'd1, 4'd4},
      {3'd3, 4'd6, 3'd0, 4'd3},   // R5 younger faults first in time
      {3'd3, 4'd7, 3'd2, 4'd5},   // R5 same-cycle faults
      {3'd2, 4'd5, 3'd1, 4'd4},
      {3'd7, 4'd0, 3'd3, 4'd8},
      {3'd1, 4'd4, 3'd0, 4'd2},
      {3'd7, 4'd0, 3'd0, 4'd2}
   };

   function automatic logic [3:0] code_at(input int st, input int cyc,
         input int a_s, input logic [3:0] a_c, input int a_s2, input logic [3:0] a_c2,
         input int b_s, input logic [3:0] b_c);
      code_at = 4'd0;
      if (cyc == st && a_s == st) code_at = a_c;
      else if (cyc == st && a_s2 == st) code_at = a_c2;
      else if (cyc == st + 1 && b_s == st) code_at = b_c;
   endfunction

   task automatic run_case(input int idx, input int a_s, input logic [3:0] a_c,
         input int a_s2, input logic [3:0] a_c2, input int b_s, input logic [3:0] b_c,
         input int irq_c, input bit extra);
      logic [31:0] pa, pb, pe;
      int a_eff;
      logic [3:0] a_code;
      bit a_f, b_f;
      pa = 32'h1000 + 32'(idx) * 32'h100;
      pb = pa + 32'd4;
      pe = pa + 32'h40;
      a_eff = NONE_S; a_code = 4'd0;
      if (a_s < a_eff) begin a_eff = a_s; a_code = a_c; end
      if (a_s2 < a_eff) begin a_eff = a_s2; a_code = a_c2; end
      if (irq_c <= 3 && irq_c < a_eff) begin a_eff = irq_c; a_code = 4'd9; end
      a_f = (a_eff <= 3);
      b_f = (b_s <= 3);
      for (int cyc = 0; cyc < 12; cyc++) begin
         @(negedge clk);
         fetch_valid = (cyc <= 1) || (extra && cyc >= 4 && cyc <= 6);
         fetch_pc    = (cyc == 0) ? pa : (cyc == 1) ? pb : (cyc == 6) ? pe : pa + 32'h80 + 32'(cyc) * 4;
         if_exc  = code_at(0, cyc, a_s, a_c, a_s2, a_c2, b_s, b_c);
         id_exc  = code_at(1, cyc, a_s, a_c, a_s2, a_c2, b_s, b_c);
         ex_exc  = code_at(2, cyc, a_s, a_c, a_s2, a_c2, b_s, b_c);
         mem_exc = code_at(3, cyc, a_s, a_c, a_s2, a_c2, b_s, b_c);
         irq     = (cyc == irq_c);
         #1;
         if (cyc == 3) check(store_ok == !a_f, "R8 store qualifier", 32'(store_ok), 32'(!a_f));
         if (cyc == 4) begin
            if (a_f) check(flush && !commit, "R3 trap at writeback", {commit, flush}, 32'h1);
            else check(commit && commit_pc == pa, "R2 older commit", commit_pc, pa);
         end
         if (cyc == 5) begin
            if (a_f) begin
               check(redirect && redirect_pc == HANDLER, "R7 redirect", redirect_pc, HANDLER);
               check(!commit, "R5 younger squashed", 32'(commit), 32'h0);
            end else if (b_f) check(flush && !commit, "R3 younger trap", {commit, flush}, 32'h1);
            else check(commit && commit_pc == pb, "R2 younger commit", commit_pc, pb);
         end
         if (cyc == 6 && !a_f && b_f) check(redirect, "R7 redirect", 32'(redirect), 32'h1);
         if (extra && (cyc == 8 || cyc == 9))
            check(!commit, "R6 dropped fetch", 32'(commit), 32'h0);
         if (extra && cyc == 10)
            check(commit && commit_pc == pe, "R6 refetch commits", commit_pc, pe);
      end
      @(negedge clk);
      fetch_valid = 1'b0; if_exc = '0; id_exc = '0; ex_exc = '0; mem_exc = '0; irq = 1'b0;
      if (a_f) begin exp_epc = pa; exp_cause = a_code; end
      else if (b_f) begin exp_epc = pb; exp_cause = b_c; end
      #1;
      check(epc == exp_epc, (a_f || b_f) ? "R3 saved pc" : "R10 saved pc held", epc, exp_epc);
      check(cause == exp_cause, (a_f || b_f) ? "R3 saved cause" : "R10 saved cause held",
            32'(cause), 32'(exp_cause));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check(!commit && !flush && !redirect, "R1 idle outputs", {commit, flush, redirect}, 32'h0);
      check(epc == 0 && cause == 0, "R1 saved state clear", epc, 32'h0);

      for (int i = 0; i < NV; i++)
         run_case(i, int'(VEC[i][13:11]), VEC[i][10:7], NONE_S, 4'd0,
                  int'(VEC[i][6:4]), VEC[i][3:0], 99, 1'b0);

      // R4: decode fault kept over a later execute fault
      run_case(20, 1, 4'd4, 2, 4'd5, NONE_S, 4'd0, 99, 1'b0);
      // R4: fetch fault kept over a later memory fault
      run_case(21, 0, 4'd2, 3, 4'd8, NONE_S, 4'd0, 99, 1'b0);
      // R6: fetches in trap and redirect cycles are dropped, later one retires
      run_case(22, 2, 4'd5, NONE_S, 4'd0, NONE_S, 4'd0, 99, 1'b1);
      // R9: interrupt lands on oldest (execute stage)
      run_case(23, NONE_S, 4'd0, NONE_S, 4'd0, NONE_S, 4'd0, 2, 1'b0);
      // R9: interrupt with only the fetch stage occupied
      run_case(24, NONE_S, 4'd0, NONE_S, 4'd0, NONE_S, 4'd0, 0, 1'b0);
      // R9: synchronous decode fault wins in the same cycle
      run_case(25, 1, 4'd4, NONE_S, 4'd0, NONE_S, 4'd0, 1, 1'b0);
      // R9: interrupt recorded before a later execute overflow
      run_case(26, 2, 4'd5, NONE_S, 4'd0, NONE_S, 4'd0, 1, 1'b0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule